// File: doc/BRIEF.md
# ADC Conversion Start Controller

This block is the digital front end of a successive-approximation converter. A three-bit mode field picks which event starts a conversion: a software write of 1 to the busy bit, an overflow pulse from timer 0, 2 or 3, or a rising edge on an asynchronous external start pin. When the selected event fires while the block is idle, it pulses a start strobe to the converter. It then holds busy high until the converter reports completion. On that same edge it captures the result and raises a sticky completion flag.

The block also produces the conversion clock as a one-cycle enable. It divides either the system clock or a low-power oscillator tick, chosen by a burst-enable bit. The divide ratio must be set so that the converter stays within its 300 ksps ceiling. For timers 2 and 3, a width input per timer chooses between the low-byte overflow (8-bit mode) and the high-byte overflow (16-bit mode). The analog converter is outside the block and is reached through a start/done/data handshake.

Top module: `adc_start_ctrl`

## Requirements
- R1: In mode 0 (software), a cycle with `sw_busy_wr`=1 and `sw_busy_data`=1 while idle starts a conversion: `sar_start` pulses in that cycle and `busy` reads 1 after the next clock edge.
- R2: In mode 1, a `tmr0_ovf` pulse while idle starts a conversion, with `busy` 1 after the next edge.
- R3: In mode 2 (timer 2) and mode 3 (timer 3), the trigger is the high-byte overflow when the timer's wide input is 1 and the low-byte overflow when it is 0; the other overflow of that timer is ignored.
- R4: In mode 4, `cnv_pin` passes through two synchronizer flops and a rising-edge detector: a pin that rises before clock edge k makes `busy` read 1 after edge k+2, and a pin held high starts only one conversion. Modes 5 to 7 never start a conversion.
- R5: Events from sources other than the selected one, and any event that arrives while `busy` is 1, are ignored and are not queued.
- R6: `busy` stays 1 until `sar_done`. On the edge where `busy` falls, `result` loads `sar_data` and `done_flag` becomes 1, so `result` is valid whenever the flag is 1.
- R7: `done_flag` is sticky. Only a cycle with `sw_flag_wr`=1 and `sw_flag_data`=0 clears it. Writing 1 does not set it, and starting a new conversion does not clear it. If a completion and a clear fall in the same cycle, the completion wins.
- R8: `irq` equals `done_flag` AND `irq_en`.
- R9: `conv_tick` pulses once every `cfg_div`+1 source ticks. The source is every system clock cycle when `cfg_burst`=0, and each `lp_tick` pulse when `cfg_burst`=1.
- R10: After reset, `busy`, `done_flag`, `irq` and `result` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 3 | Start source: 0 soft, 1 timer0, 2 timer2, 3 timer3, 4 pin |
| cfg_burst | input | 1 | 1 divides the low-power tick, 0 the system clock |
| cfg_div | input | DIV_W | Conversion clock divide minus one |
| t2_wide | input | 1 | Timer 2 is in 16-bit mode |
| t3_wide | input | 1 | Timer 3 is in 16-bit mode |
| irq_en | input | 1 | Interrupt enable |
| sw_busy_wr | input | 1 | Software write strobe for the busy bit |
| sw_busy_data | input | 1 | Value written to the busy bit |
| sw_flag_wr | input | 1 | Software write strobe for the completion flag |
| sw_flag_data | input | 1 | Value written to the completion flag |
| tmr0_ovf | input | 1 | Timer 0 overflow pulse |
| tmr2_lo_ovf | input | 1 | Timer 2 low-byte overflow pulse |
| tmr2_hi_ovf | input | 1 | Timer 2 high-byte overflow pulse |
| tmr3_lo_ovf | input | 1 | Timer 3 low-byte overflow pulse |
| tmr3_hi_ovf | input | 1 | Timer 3 high-byte overflow pulse |
| lp_tick | input | 1 | Low-power oscillator tick, synchronous enable |
| cnv_pin | input | 1 | Asynchronous external start input |
| sar_done | input | 1 | Converter completion pulse |
| sar_data | input | DATA_W | Converter output data |
| sar_start | output | 1 | Conversion start strobe |
| conv_tick | output | 1 | Conversion clock enable |
| busy | output | 1 | Conversion in progress |
| done_flag | output | 1 | Sticky completion flag |
| irq | output | 1 | Interrupt request |
| result | output | DATA_W | Captured conversion result |

## Verification
The bench crosses the timer 2 and timer 3 width settings with both overflow pulses. A design that ties the wrong byte to a mode starts on the ignored pulse, or never starts at all. It fires every source while a conversion runs and while the mode points elsewhere. A design that queues or leaks triggers shows an unexpected completion, and the scoreboard reports it. It counts edges on the external pin exactly, and holds the pin high. A missing synchronizer stage shifts busy by a cycle, and level triggering starts repeated conversions. It also writes 1 to the flag, and starts a conversion over a set flag, to catch a flag that is not truly sticky. Last, it counts conversion ticks with burst mode on and with the low-power tick stopped, so a divider that still runs from the system clock is exposed.

// File: rtl/adc_start_pkg.sv
package adc_start_pkg;
    typedef enum logic [2:0] {
        SOC_SOFT = 3'd0,
        SOC_TMR0 = 3'd1,
        SOC_TMR2 = 3'd2,
        SOC_TMR3 = 3'd3,
        SOC_PIN  = 3'd4
    } soc_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_CONV = 1'b1
    } seq_state_e;
endpackage

// File: rtl/adc_conv_clkdiv.sv
module adc_conv_clkdiv #(
    parameter int DIV_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             burst,
    input  logic             lp_tick,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;
    logic             src;
    logic             wrap;

    assign src  = burst ? lp_tick : 1'b1;
    assign wrap = (cnt_q >= div);
    assign tick = src && wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (src) begin
            cnt_q <= wrap ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/adc_trig_sel.sv
module adc_trig_sel
    import adc_start_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode,
    input  logic       sw_go,
    input  logic       t0_ovf,
    input  logic       t2_lo,
    input  logic       t2_hi,
    input  logic       t2_wide,
    input  logic       t3_lo,
    input  logic       t3_hi,
    input  logic       t3_wide,
    input  logic       pin,
    output logic       fire
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;
    logic                   pin_rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
            last_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign pin_rise = sync_q[SYNC_STAGES-1] && !last_q;

    always_comb begin
        case (soc_mode_e'(mode))
            SOC_SOFT: fire = sw_go;
            SOC_TMR0: fire = t0_ovf;
            SOC_TMR2: fire = t2_wide ? t2_hi : t2_lo;
            SOC_TMR3: fire = t3_wide ? t3_hi : t3_lo;
            SOC_PIN:  fire = pin_rise;
            default:  fire = 1'b0;
        endcase
    end
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
    import adc_start_pkg::*;
#(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic              sar_done,
    input  logic [DATA_W-1:0] sar_data,
    input  logic              flag_wr,
    input  logic              flag_data,
    output logic              sar_start,
    output logic              busy,
    output logic              flag,
    output logic [DATA_W-1:0] result
);
    seq_state_e state_q, state_d;
    logic       finish;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (fire)     state_d = ST_CONV;
            ST_CONV: if (sar_done) state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        sar_start = 1'b0;
        busy      = 1'b0;
        finish    = 1'b0;
        unique case (state_q)
            ST_IDLE: sar_start = fire;
            ST_CONV: begin
                busy   = 1'b1;
                finish = sar_done;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag   <= 1'b0;
            result <= '0;
        end else if (finish) begin
            flag   <= 1'b1;
            result <= sar_data;
        end else if (flag_wr && !flag_data) begin
            flag   <= 1'b0;
        end
    end
endmodule

// File: rtl/adc_start_ctrl.sv
module adc_start_ctrl #(
    parameter int DATA_W = 10,
    parameter int DIV_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cfg_mode,
    input  logic              cfg_burst,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              t2_wide,
    input  logic              t3_wide,
    input  logic              irq_en,
    input  logic              sw_busy_wr,
    input  logic              sw_busy_data,
    input  logic              sw_flag_wr,
    input  logic              sw_flag_data,
    input  logic              tmr0_ovf,
    input  logic              tmr2_lo_ovf,
    input  logic              tmr2_hi_ovf,
    input  logic              tmr3_lo_ovf,
    input  logic              tmr3_hi_ovf,
    input  logic              lp_tick,
    input  logic              cnv_pin,
    input  logic              sar_done,
    input  logic [DATA_W-1:0] sar_data,
    output logic              sar_start,
    output logic              conv_tick,
    output logic              busy,
    output logic              done_flag,
    output logic              irq,
    output logic [DATA_W-1:0] result
);
    logic fire;

    adc_conv_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .burst   (cfg_burst),
        .lp_tick (lp_tick),
        .div     (cfg_div),
        .tick    (conv_tick)
    );

    adc_trig_sel #(.SYNC_STAGES(2)) u_trig (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (cfg_mode),
        .sw_go   (sw_busy_wr && sw_busy_data),
        .t0_ovf  (tmr0_ovf),
        .t2_lo   (tmr2_lo_ovf),
        .t2_hi   (tmr2_hi_ovf),
        .t2_wide (t2_wide),
        .t3_lo   (tmr3_lo_ovf),
        .t3_hi   (tmr3_hi_ovf),
        .t3_wide (t3_wide),
        .pin     (cnv_pin),
        .fire    (fire)
    );

    adc_conv_seq #(.DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (fire),
        .sar_done  (sar_done),
        .sar_data  (sar_data),
        .flag_wr   (sw_flag_wr),
        .flag_data (sw_flag_data),
        .sar_start (sar_start),
        .busy      (busy),
        .flag      (done_flag),
        .result    (result)
    );

    assign irq = done_flag && irq_en;
endmodule

// File: rtl/adc_start_ctrl_chk.sv
module adc_start_ctrl_chk #(
    parameter int DATA_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_burst,
    input logic              lp_tick,
    input logic              irq_en,
    input logic              sw_flag_wr,
    input logic              sw_flag_data,
    input logic              sar_start,
    input logic              conv_tick,
    input logic              busy,
    input logic              done_flag,
    input logic              irq,
    input logic [DATA_W-1:0] result
);
    AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        sar_start |-> !busy);                                          // R5
    AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        sar_start |=> busy);                                           // R1
    AST_FALL_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done_flag);                                    // R6
    AST_RESULT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> $fell(busy));                             // R6
    AST_FLAG_CLEAR_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done_flag) |-> $past(sw_flag_wr && !sw_flag_data));      // R7
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (done_flag && irq_en));                                // R8
    AST_BURST_TICK_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_burst && !lp_tick) |-> !conv_tick);                       // R9
endmodule

bind adc_start_ctrl adc_start_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_burst    (cfg_burst),
    .lp_tick      (lp_tick),
    .irq_en       (irq_en),
    .sw_flag_wr   (sw_flag_wr),
    .sw_flag_data (sw_flag_data),
    .sar_start    (sar_start),
    .conv_tick    (conv_tick),
    .busy         (busy),
    .done_flag    (done_flag),
    .irq          (irq),
    .result       (result)
);

// File: tb/adc_start_ctrl_test.sv
module sar_stub #(
    parameter int DATA_W = 10,
    parameter int STEPS  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              tick,
    input  logic [DATA_W-1:0] value,
    output logic              done,
    output logic [DATA_W-1:0] data
);
    logic     active;
    int       cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt    <= 0;
            done   <= 1'b0;
            data   <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                active <= 1'b1;
                cnt    <= 0;
            end else if (active && tick) begin
                if (cnt == STEPS - 1) begin
                    active <= 1'b0;
                    done   <= 1'b1;
                    data   <= value;
                end else begin
                    cnt <= cnt + 1;
                end
            end
        end
    end
endmodule

module adc_start_ctrl_test;
    localparam int DATA_W = 10;
    localparam int DIV_W  = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] cfg_mode = 3'd0;
    logic cfg_burst = 1'b0;
    logic [DIV_W-1:0] cfg_div = 5'd1;
    logic t2_wide = 1'b0, t3_wide = 1'b0, irq_en = 1'b0;
    logic sw_busy_wr = 1'b0, sw_busy_data = 1'b0;
    logic sw_flag_wr = 1'b0, sw_flag_data = 1'b0;
    logic tmr0_ovf = 1'b0, tmr2_lo_ovf = 1'b0, tmr2_hi_ovf = 1'b0;
    logic tmr3_lo_ovf = 1'b0, tmr3_hi_ovf = 1'b0;
    logic lp_tick = 1'b0, cnv_pin = 1'b0;
    logic sar_done;
    logic [DATA_W-1:0] sar_data;
    logic sar_start, conv_tick, busy, done_flag, irq;
    logic [DATA_W-1:0] result;
    logic [DATA_W-1:0] stub_value = '0;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    logic [DATA_W-1:0] exp_q[$];

    always #5 clk = ~clk;

    adc_start_ctrl #(.DATA_W(DATA_W), .DIV_W(DIV_W)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_burst(cfg_burst),
        .cfg_div(cfg_div), .t2_wide(t2_wide), .t3_wide(t3_wide), .irq_en(irq_en),
        .sw_busy_wr(sw_busy_wr), .sw_busy_data(sw_busy_data),
        .sw_flag_wr(sw_flag_wr), .sw_flag_data(sw_flag_data),
        .tmr0_ovf(tmr0_ovf), .tmr2_lo_ovf(tmr2_lo_ovf), .tmr2_hi_ovf(tmr2_hi_ovf),
        .tmr3_lo_ovf(tmr3_lo_ovf), .tmr3_hi_ovf(tmr3_hi_ovf), .lp_tick(lp_tick),
        .cnv_pin(cnv_pin), .sar_done(sar_done), .sar_data(sar_data),
        .sar_start(sar_start), .conv_tick(conv_tick), .busy(busy),
        .done_flag(done_flag), .irq(irq), .result(result)
    );

    sar_stub #(.DATA_W(DATA_W), .STEPS(3)) u_stub (
        .clk(clk), .rst_n(rst_n), .start(sar_start), .tick(conv_tick),
        .value(stub_value), .done(sar_done), .data(sar_data)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Monitor: every completion pops one expected result.
    logic prev_busy = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_busy && !busy) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5", "unexpected completion", 1, 0);
                end else begin
                    logic [DATA_W-1:0] e;
                    e = exp_q.pop_front();
                    check(result == e, "R6", "result at busy fall", int'(result), int'(e));
                    check(done_flag == 1'b1, "R6", "flag at busy fall", int'(done_flag), 1);
                end
            end
            prev_busy <= busy;
        end
    end

    // Driver: which = 0 sw, 1 t0, 2 t2lo, 3 t2hi, 4 t3lo, 5 t3hi.
    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: begin sw_busy_wr = 1'b1; sw_busy_data = 1'b1; end
            1: tmr0_ovf = 1'b1;
            2: tmr2_lo_ovf = 1'b1;
            3: tmr2_hi_ovf = 1'b1;
            4: tmr3_lo_ovf = 1'b1;
            default: tmr3_hi_ovf = 1'b1;
        endcase
        @(negedge clk);
        sw_busy_wr = 1'b0; sw_busy_data = 1'b0;
        tmr0_ovf = 1'b0; tmr2_lo_ovf = 1'b0; tmr2_hi_ovf = 1'b0;
        tmr3_lo_ovf = 1'b0; tmr3_hi_ovf = 1'b0;
    endtask

    task automatic start_expect(input int which, input logic [DATA_W-1:0] d,
                                input string req);
        stub_value = d;
        exp_q.push_back(d);
        pulse(which);
        check(busy == 1'b1, req, "busy after trigger", int'(busy), 1);
    endtask

    task automatic ignore_expect(input int which, input string req);
        pulse(which);
        check(busy == 1'b0, req, "busy after ignored trigger", int'(busy), 0);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 200 && busy; i++) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        check(busy == 1'b0, "R10", "busy in reset", int'(busy), 0);
        check(done_flag == 1'b0, "R10", "flag in reset", int'(done_flag), 0);
        check(result == '0, "R10", "result in reset", int'(result), 0);
        check(irq == 1'b0, "R10", "irq in reset", int'(irq), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 software start
        cfg_mode = 3'd0;
        start_expect(0, 10'h155, "R1");
        wait_idle();
        check(done_flag == 1'b1, "R6", "flag after completion", int'(done_flag), 1);
        check(irq == 1'b0, "R8", "irq with enable low", int'(irq), 0);
        irq_en = 1'b1; #1;
        check(irq == 1'b1, "R8", "irq with enable high", int'(irq), 1);

        // R7 clear by write 0, write 1 has no effect
        @(negedge clk); sw_flag_wr = 1'b1; sw_flag_data = 1'b0;
        @(negedge clk); sw_flag_wr = 1'b0;
        check(done_flag == 1'b0, "R7", "flag after write 0", int'(done_flag), 0);
        check(irq == 1'b0, "R8", "irq follows flag", int'(irq), 0);
        sw_flag_wr = 1'b1; sw_flag_data = 1'b1;
        @(negedge clk); sw_flag_wr = 1'b0; sw_flag_data = 1'b0;
        check(done_flag == 1'b0, "R7", "flag after write 1", int'(done_flag), 0);

        // R2 timer 0, with software write ignored in this mode (R5)
        cfg_mode = 3'd1;
        ignore_expect(0, "R5");
        start_expect(1, 10'h2AA, "R2");
        pulse(1);
        pulse(0);
        check(busy == 1'b1, "R5", "busy during retrigger", int'(busy), 1);
        wait_idle();
        repeat (8) @(negedge clk);
        check(busy == 1'b0, "R5", "no queued conversion", int'(busy), 0);

        // R7 new start does not clear flag
        cfg_mode = 3'd0;
        start_expect(0, 10'h0F0, "R7");
        check(done_flag == 1'b1, "R7", "flag kept during new conversion", int'(done_flag), 1);
        wait_idle();

        // R3 timer 2 and timer 3 byte selection
        cfg_mode = 3'd2; t2_wide = 1'b1;
        ignore_expect(2, "R3");
        ignore_expect(1, "R5");
        start_expect(3, 10'h3FF, "R3");
        wait_idle();
        t2_wide = 1'b0;
        ignore_expect(3, "R3");
        start_expect(2, 10'h001, "R3");
        wait_idle();
        cfg_mode = 3'd3; t3_wide = 1'b1;
        ignore_expect(4, "R3");
        start_expect(5, 10'h123, "R3");
        wait_idle();
        t3_wide = 1'b0;
        ignore_expect(5, "R3");
        start_expect(4, 10'h321, "R3");
        wait_idle();

        // R4 external pin: two sync stages plus edge detect
        cfg_mode = 3'd4;
        stub_value = 10'h2C3; exp_q.push_back(10'h2C3);
        @(negedge clk); cnv_pin = 1'b1;
        @(negedge clk); @(negedge clk);
        check(busy == 1'b0, "R4", "busy two edges after pin", int'(busy), 0);
        @(negedge clk);
        check(busy == 1'b1, "R4", "busy three edges after pin", int'(busy), 1);
        wait_idle();
        repeat (8) @(negedge clk);
        check(busy == 1'b0, "R4", "held pin no retrigger", int'(busy), 0);
        cnv_pin = 1'b0;
        repeat (4) @(negedge clk);

        // R4 modes 5..7 never start
        for (int m = 5; m < 8; m++) begin
            cfg_mode = 3'(m);
            for (int w = 0; w < 6; w++) pulse(w);
            cnv_pin = 1'b1; repeat (4) @(negedge clk);
            cnv_pin = 1'b0; repeat (4) @(negedge clk);
            check(busy == 1'b0, "R4", "reserved mode start", int'(busy), 0);
        end

        // R9 divider, system clock source
        begin
            int n;
            cfg_mode = 3'd0; cfg_div = 5'd3; cfg_burst = 1'b0;
            repeat (4) @(negedge clk);
            n = 0;
            for (int i = 0; i < 40; i++) begin @(negedge clk); if (conv_tick) n++; end
            check(n == 10, "R9", "ticks sys div4", n, 10);
            cfg_burst = 1'b1; cfg_div = 5'd1;
            n = 0;
            for (int i = 0; i < 40; i++) begin @(negedge clk); if (conv_tick) n++; end
            check(n == 0, "R9", "ticks burst lp stopped", n, 0);
            for (int i = 0; i < 8; i++) begin @(negedge clk); lp_tick = ~lp_tick; end
            n = 0;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if (conv_tick) n++;
                lp_tick = ~lp_tick;
            end
            check(n == 10, "R9", "ticks burst lp/2 div2", n, 10);
            lp_tick = 1'b0; cfg_burst = 1'b0;
        end
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R6", "all conversions completed", exp_q.size(), 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule